// File: doc/BRIEF.md
# XNOR-Popcount Outer-Product Tile Accumulator

This block keeps a bank of square accumulator tiles, each DIM×DIM elements of 32 bits, where DIM is the vector length divided by 32. One operation takes a row-source vector and a column-source vector, each DIM elements of 32 bits. For each tile position (r, c) it forms the bitwise XNOR of row-source element r and column-source element c, counts the one bits in that result, and adds the count to the accumulator already stored at (r, c) in the selected tile. The tile is updated in place.

Each source has its own byte-granular predicate mask. The row mask gates whole rows and the column mask gates whole columns. A position is updated only when both its row and its column are active. Any other position keeps its stored value. Operands enter through a valid/ready handshake. The block then walks the tile one row per clock and signals completion with a single-cycle done pulse. A combinational readback port exposes any element of any tile.

Top module: `xnp_outer_acc`

## Requirements
- R1: After reset every element of every tile reads zero, `in_ready` is high and `done` is low.
- R2: Tile element (r, c) is read back at linear index r*DIM + c. It accumulates from row-source element r (bits 32r+31..32r of `row_vec`) and column-source element c (bits 32c+31..32c of `col_vec`).
- R3: The amount added to an active element is the number of one bits in NOT(a XOR b), a value from 0 to 32. Equal operands add 32 and bitwise complements add 0.
- R4: Successive operations on the same tile accumulate: the new value is the stored value plus the count, taken modulo 2^32.
- R5: Row r is active when bit 4r of `row_pred` is 1. Every element of an inactive row keeps its value.
- R6: Column c is active when bit 4c of `col_pred` is 1. Every element of an inactive column keeps its value.
- R7: Predicate bits at positions that are not a multiple of 4 have no effect on the result.
- R8: Only the tile selected by `in_tile` (0 to NTILE-1), captured at acceptance, changes. All other tiles keep their contents.
- R9: An operation is accepted on a rising edge where `in_valid` and `in_ready` are both high. `in_ready` is then low for exactly DIM cycles. `done` is high for exactly one cycle, starting right after the DIM-th rising edge following acceptance, and `in_ready` returns high in that same cycle.
- R10: `in_valid` asserted while `in_ready` is low is ignored: the tile contents and the operation in progress are unaffected.
- R11: `rd_data` shows, in the same cycle and without a clock edge, the element of tile `rd_tile` at linear index `rd_idx`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand set offered |
| in_ready | output | 1 | Block idle and able to accept an operand set |
| in_tile | input | $clog2(NTILE) | Destination tile select |
| row_vec | input | VL | Row-source vector, DIM elements of 32 bits |
| col_vec | input | VL | Column-source vector, DIM elements of 32 bits |
| row_pred | input | VL/8 | Row predicate, one bit per byte |
| col_pred | input | VL/8 | Column predicate, one bit per byte |
| done | output | 1 | One-cycle completion pulse |
| rd_tile | input | $clog2(NTILE) | Readback tile select |
| rd_idx | input | 2*$clog2(DIM) | Readback linear index r*DIM + c |
| rd_data | output | 32 | Readback element value |

## Verification
Operands are accepted on the rising edge where `in_valid` and `in_ready` are both high. Row k of the tile is written on the (k+1)-th edge after acceptance, and `done` is visible in the cycle after the DIM-th edge. The bench drives inputs on falling edges and samples `in_ready` and `done` on each falling edge that follows. It compares the tile contents only after `done` has been seen. Readback is combinational, so each readback value is sampled one nanosecond after the falling edge that sets `rd_tile` and `rd_idx`. Every element of all tiles is compared with a model after each operation, so that an update to the wrong position or to an unselected tile is detected.

// File: rtl/xnp_pkg.sv
package xnp_pkg;
  localparam int EW = 32;
  localparam int CW = $clog2(EW + 1);
  localparam int PRED_STRIDE = EW / 8;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } xnp_state_e;
endpackage

// File: rtl/xnp_xnor_popcnt.sv
module xnp_xnor_popcnt #(
  parameter int EW = 32,
  parameter int CW = $clog2(EW + 1)
) (
  input  logic [EW-1:0] op_a,
  input  logic [EW-1:0] op_b,
  output logic [CW-1:0] ones
);
  logic [EW-1:0] agree;
  assign agree = ~(op_a ^ op_b);

  always_comb begin
    ones = '0;
    for (int i = 0; i < EW; i++) begin
      ones = ones + CW'(agree[i]);
    end
  end
endmodule

// File: rtl/xnp_row_unit.sv
module xnp_row_unit #(
  parameter int EW  = 32,
  parameter int DIM = 4
) (
  input  logic              en,
  input  logic              row_act,
  input  logic [DIM-1:0]    col_act,
  input  logic [EW-1:0]     row_elem,
  input  logic [DIM*EW-1:0] col_elems,
  input  logic [DIM*EW-1:0] old_row,
  output logic [DIM*EW-1:0] new_row,
  output logic [DIM-1:0]    lane_we
);
  localparam int CW = $clog2(EW + 1);

  for (genvar c = 0; c < DIM; c++) begin : g_lane
    logic [CW-1:0] cnt;
    xnp_xnor_popcnt #(.EW(EW), .CW(CW)) u_pc (
      .op_a (row_elem),
      .op_b (col_elems[c*EW +: EW]),
      .ones (cnt)
    );
    assign new_row[c*EW +: EW] = old_row[c*EW +: EW] + EW'(cnt);
    assign lane_we[c] = en & row_act & col_act[c];
  end
endmodule

// File: rtl/xnp_ctrl.sv
module xnp_ctrl #(
  parameter int DIM = 4,
  parameter int RW  = $clog2(DIM)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  output logic          accept,
  output logic          busy,
  output logic [RW-1:0] row_idx,
  output logic          done
);
  import xnp_pkg::*;

  xnp_state_e state_q;
  logic [RW-1:0] row_q;
  logic done_q;

  assign in_ready = (state_q == ST_IDLE);
  assign busy     = (state_q == ST_RUN);
  assign accept   = in_valid & in_ready;
  assign row_idx  = row_q;
  assign done     = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      row_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            state_q <= ST_RUN;
            row_q   <= '0;
          end
        end
        ST_RUN: begin
          if (row_q == RW'(DIM - 1)) begin
            state_q <= ST_IDLE;
            row_q   <= '0;
            done_q  <= 1'b1;
          end else begin
            row_q <= row_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/xnp_tile_store.sv
module xnp_tile_store #(
  parameter int EW    = 32,
  parameter int DIM   = 4,
  parameter int NTILE = 4,
  parameter int TW    = $clog2(NTILE),
  parameter int RW    = $clog2(DIM)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TW-1:0]     wr_tile,
  input  logic [RW-1:0]     wr_row,
  input  logic [DIM-1:0]    wr_en,
  input  logic [DIM*EW-1:0] wr_data,
  output logic [DIM*EW-1:0] cur_row,
  input  logic [TW-1:0]     rb_tile,
  input  logic [RW-1:0]     rb_row,
  input  logic [RW-1:0]     rb_col,
  output logic [EW-1:0]     rb_data
);
  logic [EW-1:0] mem [NTILE][DIM][DIM];

  for (genvar c = 0; c < DIM; c++) begin : g_col
    assign cur_row[c*EW +: EW] = mem[wr_tile][wr_row][c];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int t = 0; t < NTILE; t++) begin
          for (int r = 0; r < DIM; r++) begin
            mem[t][r][c] <= '0;
          end
        end
      end else if (wr_en[c]) begin
        mem[wr_tile][wr_row][c] <= wr_data[c*EW +: EW];
      end
    end
  end

  assign rb_data = mem[rb_tile][rb_row][rb_col];
endmodule

// File: rtl/xnp_outer_acc.sv
module xnp_outer_acc #(
  parameter int VL    = 128,
  parameter int NTILE = 4,
  localparam int EW   = xnp_pkg::EW,
  localparam int DIM  = VL / EW,
  localparam int PL   = VL / 8,
  localparam int TW   = $clog2(NTILE),
  localparam int RW   = $clog2(DIM),
  localparam int IW   = 2 * RW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [TW-1:0] in_tile,
  input  logic [VL-1:0] row_vec,
  input  logic [VL-1:0] col_vec,
  input  logic [PL-1:0] row_pred,
  input  logic [PL-1:0] col_pred,
  output logic          done,
  input  logic [TW-1:0] rd_tile,
  input  logic [IW-1:0] rd_idx,
  output logic [EW-1:0] rd_data
);
  import xnp_pkg::*;

  logic          accept;
  logic          busy;
  logic [RW-1:0] row_idx;

  logic [DIM-1:0] ract_d, cact_d;
  logic [DIM-1:0] ract_q, cact_q;
  logic [VL-1:0]  a_q, b_q;
  logic [TW-1:0]  tile_q;

  logic [DIM*EW-1:0] row_old, row_new;
  logic [DIM-1:0]    row_we;

  for (genvar i = 0; i < DIM; i++) begin : g_pred
    assign ract_d[i] = row_pred[i*PRED_STRIDE];
    assign cact_d[i] = col_pred[i*PRED_STRIDE];
  end

  logic unused_pred_bits;
  assign unused_pred_bits = ^{row_pred, col_pred};

  xnp_ctrl #(.DIM(DIM), .RW(RW)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .accept   (accept),
    .busy     (busy),
    .row_idx  (row_idx),
    .done     (done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q    <= '0;
      b_q    <= '0;
      ract_q <= '0;
      cact_q <= '0;
      tile_q <= '0;
    end else if (accept) begin
      a_q    <= row_vec;
      b_q    <= col_vec;
      ract_q <= ract_d;
      cact_q <= cact_d;
      tile_q <= in_tile;
    end
  end

  xnp_row_unit #(.EW(EW), .DIM(DIM)) u_row (
    .en        (busy),
    .row_act   (ract_q[row_idx]),
    .col_act   (cact_q),
    .row_elem  (a_q[row_idx*EW +: EW]),
    .col_elems (b_q),
    .old_row   (row_old),
    .new_row   (row_new),
    .lane_we   (row_we)
  );

  xnp_tile_store #(.EW(EW), .DIM(DIM), .NTILE(NTILE), .TW(TW), .RW(RW)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_tile (tile_q),
    .wr_row  (row_idx),
    .wr_en   (row_we),
    .wr_data (row_new),
    .cur_row (row_old),
    .rb_tile (rd_tile),
    .rb_row  (rd_idx[IW-1:RW]),
    .rb_col  (rd_idx[RW-1:0]),
    .rb_data (rd_data)
  );
endmodule

// File: rtl/xnp_outer_acc_chk.sv
module xnp_outer_acc_chk #(
  parameter int EW  = 32,
  parameter int DIM = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              done,
  input logic              busy,
  input logic [DIM-1:0]    row_we,
  input logic [DIM*EW-1:0] row_old,
  input logic [DIM*EW-1:0] row_new
);
  // R9: acceptance makes the block busy on the next cycle
  assert_ready_drops_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  // R9: done is a single-cycle pulse
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9: done follows a busy cycle and comes with in_ready high
  assert_done_after_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(!in_ready) && in_ready));

  // R10: tile writes only happen while an operation is in progress
  assert_write_only_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (|row_we) |-> (busy && !in_ready));

  for (genvar c = 0; c < DIM; c++) begin : g_lane_chk
    // R3: a single update adds at most 32
    assert_incr_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
      row_we[c] |-> ((row_new[c*EW +: EW] - row_old[c*EW +: EW]) <= EW));
  end
endmodule

bind xnp_outer_acc xnp_outer_acc_chk #(.EW(EW), .DIM(DIM)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .done     (done),
  .busy     (busy),
  .row_we   (row_we),
  .row_old  (row_old),
  .row_new  (row_new)
);

// File: tb/sim_xnp_outer_acc.sv
`timescale 1ns/1ps
module sim_xnp_outer_acc;
  localparam int VL = 128;
  localparam int NT = 4;
  localparam int DIM = VL / 32;
  localparam int PL = VL / 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [1:0] in_tile = '0;
  logic [VL-1:0] row_vec = '0, col_vec = '0;
  logic [PL-1:0] row_pred = '0, col_pred = '0;
  logic done;
  logic [1:0] rd_tile = '0;
  logic [3:0] rd_idx = '0;
  logic [31:0] rd_data;

  int checks = 0;
  int errors = 0;
  logic [31:0] mdl [NT][DIM][DIM];

  always #2.5 clk = ~clk;

  xnp_outer_acc #(.VL(VL), .NTILE(NT)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_tile(in_tile), .row_vec(row_vec), .col_vec(col_vec),
    .row_pred(row_pred), .col_pred(col_pred), .done(done),
    .rd_tile(rd_tile), .rd_idx(rd_idx), .rd_data(rd_data)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic compare_all(input string req);
    for (int t = 0; t < NT; t++)
      for (int r = 0; r < DIM; r++)
        for (int c = 0; c < DIM; c++) begin
          @(negedge clk);
          rd_tile = 2'(t);
          rd_idx = 4'(r * DIM + c);
          #1;
          check(req, rd_data, mdl[t][r][c]);
        end
  endtask

  // Runs one operation with timing checks (R9) and model update.
  task automatic run_op(input int tile, input logic [VL-1:0] a, input logic [VL-1:0] b,
                        input logic [PL-1:0] pa, input logic [PL-1:0] pb, input string req);
    for (int r = 0; r < DIM; r++)
      for (int c = 0; c < DIM; c++)
        if (pa[r*4] && pb[c*4])
          mdl[tile][r][c] += 32'($countones(~(a[r*32 +: 32] ^ b[c*32 +: 32])));
    @(negedge clk);
    check("R9 ready before accept", {31'd0, in_ready}, 32'd1);
    in_valid = 1'b1; in_tile = 2'(tile);
    row_vec = a; col_vec = b; row_pred = pa; col_pred = pb;
    @(negedge clk);
    in_valid = 1'b0;
    row_vec = '1; col_vec = '0; row_pred = '1; col_pred = '1; in_tile = 2'(tile + 1);
    for (int k = 1; k <= DIM; k++) begin
      check("R9 ready low while busy", {31'd0, in_ready}, 32'd0);
      check("R9 done low while busy", {31'd0, done}, 32'd0);
      if (k < DIM) @(negedge clk);
    end
    @(negedge clk);
    check("R9 done pulse", {31'd0, done}, 32'd1);
    check("R9 ready with done", {31'd0, in_ready}, 32'd1);
    @(negedge clk);
    check("R9 done one cycle", {31'd0, done}, 32'd0);
    compare_all(req);
  endtask

  function automatic logic [VL-1:0] vec4(input logic [31:0] e3, input logic [31:0] e2,
                                         input logic [31:0] e1, input logic [31:0] e0);
    return {e3, e2, e1, e0};
  endfunction

  task automatic t_reset;
    check("R1 ready after reset", {31'd0, in_ready}, 32'd1);
    check("R1 done after reset", {31'd0, done}, 32'd0);
    compare_all("R1 tiles zero");
  endtask

  task automatic t_pairing;
    run_op(0, vec4(32'h0000_0000, 32'h0000_00FF, 32'h0000_FFFF, 32'h00FF_FFFF),
              vec4(32'hF000_0000, 32'h0F00_0000, 32'h0000_000F, 32'h0000_0001),
           16'h1111, 16'h1111, "R2 pairing and linear index");
  endtask

  task automatic t_extremes;
    run_op(1, vec4(32'hDEAD_BEEF, 32'h1234_5678, 32'h0000_0000, 32'hFFFF_FFFF),
              vec4(32'hDEAD_BEEF, ~32'h1234_5678, 32'hFFFF_FFFF, 32'hFFFF_FFFF),
           16'h1111, 16'h1111, "R3 equal adds 32, complement adds 0");
  endtask

  task automatic t_accum;
    for (int n = 0; n < 3; n++)
      run_op(1, vec4(32'hA5A5_0000 + 32'(n), 32'h0F0F_F0F0, 32'h8000_0001, 32'h3C3C_3C3C),
                vec4(32'h5A5A_FFFF, 32'h0F0F_0F0F, 32'h7FFF_FFFE ^ 32'(n), 32'h3C3C_0000),
             16'h1111, 16'h1111, "R4 accumulation");
  endtask

  task automatic t_rowmask;
    run_op(2, vec4(32'h1111_1111, 32'h2222_2222, 32'h4444_4444, 32'h8888_8888),
              vec4(32'h1111_1111, 32'hFFFF_0000, 32'h0000_0000, 32'hFFFF_FFFF),
           16'h0101, 16'h1111, "R5 inactive rows 1 and 3 hold");
  endtask

  task automatic t_colmask;
    run_op(2, vec4(32'h0000_0000, 32'hFFFF_FFFF, 32'h0F0F_0F0F, 32'hF0F0_F0F0),
              vec4(32'h1234_0000, 32'h0000_5678, 32'hCAFE_F00D, 32'h1357_9BDF),
           16'h1111, 16'h1010, "R6 inactive columns 0 and 2 hold");
  endtask

  task automatic t_partial;
    run_op(3, '1, '1, 16'hEEEE, 16'hEEEE, "R7 non-aligned predicate bits ignored");
    run_op(3, '0, '0, 16'h1111, 16'h1111, "R7 aligned bits only enable");
  endtask

  task automatic t_tilesel;
    run_op(0, vec4(32'h0, 32'h0, 32'h0, 32'h0), vec4(32'h0, 32'h0, 32'h0, 32'h0),
           16'h1111, 16'h1111, "R8 other tiles unchanged");
  endtask

  task automatic t_busy_ignore;
    logic [VL-1:0] a = vec4(32'hFFFF_0000, 32'h0, 32'hFFFF_FFFF, 32'h00FF_00FF);
    for (int r = 0; r < DIM; r++)
      for (int c = 0; c < DIM; c++)
        mdl[2][r][c] += 32'($countones(~(a[r*32 +: 32] ^ a[c*32 +: 32])));
    @(negedge clk);
    in_valid = 1'b1; in_tile = 2'd2; row_vec = a; col_vec = a;
    row_pred = 16'h1111; col_pred = 16'h1111;
    @(negedge clk);
    in_tile = 2'd3; row_vec = '0; col_vec = '1;
    check("R10 busy after accept", {31'd0, in_ready}, 32'd0);
    @(negedge clk);
    check("R10 second valid not taken", {31'd0, in_ready}, 32'd0);
    in_valid = 1'b0;
    for (int k = 0; k < 2 * DIM; k++) begin
      @(negedge clk);
      if (done) break;
    end
    check("R10 done reached", {31'd0, done}, 32'd1);
    @(negedge clk);
    check("R10 no second operation", {31'd0, in_ready}, 32'd1);
    compare_all("R10 tile contents unaffected");
  endtask

  task automatic t_readback;
    @(negedge clk);
    rd_tile = 2'd1; rd_idx = 4'd5;
    #1;
    check("R11 combinational readback", rd_data, mdl[1][1][1]);
    rd_tile = 2'd2; rd_idx = 4'd15;
    #1;
    check("R11 readback follows address", rd_data, mdl[2][3][3]);
  endtask

  initial begin
    for (int t = 0; t < NT; t++)
      for (int r = 0; r < DIM; r++)
        for (int c = 0; c < DIM; c++)
          mdl[t][r][c] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_pairing();
    t_extremes();
    t_accum();
    t_rowmask();
    t_colmask();
    t_partial();
    t_tilesel();
    t_busy_ignore();
    t_readback();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule